// File: doc/BRIEF.md
# Power-Down Entry and Wake Sequencer

This block decides when a small microcontroller drops into its low-power state and how it comes back out. Software programs a 9-bit control word that holds four oscillator enable requests, a wake-delay enable, a wake-interrupt enable, a wake status flag, a power-down request and an entry-mode bit. The block watches a CPU sleep indication and a vector of wake-event lines. It drives the enables for the oscillators, the PLL power-down indication and the system clock enable.

Entry into power-down happens either on the next edge after the request bit is set, or only once the CPU also reports sleep, depending on the entry-mode bit. While power-down lasts, both high-speed sources, the PLL and the system clock are forced off, and the two low-speed sources keep following their enable bits. The first wake event ends power-down. If the wake delay is enabled, the system clock stays gated for a settle period whose length depends on which high-speed source drives the system clock.

Top module: `pdwake_seq`

## Requirements
- R1: After reset every control bit reads 0, the system clock enable is 1, every oscillator enable is 0, the PLL power-down output is 0, and the wake interrupt and power-down indication are 0.
- R2: With the entry-mode bit (bit 8) at 0, setting the request bit (bit 7) puts the block into power-down on the clock edge after the write takes effect, whatever the CPU sleep input is.
- R3: With the entry-mode bit at 1, the block stays running while the CPU sleep input is low, and enters power-down on the first edge at which the request bit is 1 and CPU sleep is high.
- R4: In power-down the two high-speed enables (osc_en_o bits 0 and 1) are 0, the PLL power-down output is 1 and the system clock enable is 0. The low-speed enables (bits 2 and 3) follow their control bits 2 and 3. Outside power-down the PLL power-down output follows pll_pd_sw_i.
- R5: The first edge in power-down with any wake line high ends power-down. At that same edge the request bit clears and the status bit (bit 6) sets, so the block does not re-enter power-down until software sets the request bit again.
- R6: With the delay bit (bit 4) at 0, the system clock enable returns on the wake edge. With it at 1, the system clock stays gated for exactly 256 cycles when src_hirc_i is 1, or 4096 cycles when it is 0, counted from the wake edge.
- R7: Writing 1 to the status bit clears it. Writing 0 to it leaves it unchanged.
- R8: The wake interrupt output is 1 exactly while both the status bit and the interrupt enable bit (bit 5) are 1.
- R9: Wake lines that go high while the block is not in power-down change neither the status bit nor the system clock enable.
- R10: The control word reads back in this bit order: 0 high-speed crystal, 1 internal high-speed oscillator, 2 low-speed crystal, 3 low-speed oscillator, 4 wake delay, 5 interrupt enable, 6 status, 7 power-down request, 8 entry mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 9 | Write value |
| rd_data | output | 9 | Current control word |
| cpu_sleep_i | input | 1 | CPU reports sleep |
| wake_evt_i | input | 6 | Wake-event lines |
| src_hirc_i | input | 1 | 1 when the system clock source is the internal high-speed oscillator, 0 for the crystal |
| pll_pd_sw_i | input | 1 | Software PLL power-down request |
| osc_en_o | output | 4 | Oscillator enables, bit order as control bits 0 to 3 |
| pll_pd_o | output | 1 | PLL power-down indication |
| sysclk_en_o | output | 1 | System clock enable |
| wake_irq_o | output | 1 | Wake interrupt |
| pd_active_o | output | 1 | Block is in power-down |

## Verification
Entry is tried in two ways. In immediate mode the CPU sleep input stays low, so an entry there can only come from the request bit. In CPU-wait mode the sleep input is held low for several cycles and then raised, which separates waiting from entering. Wake is tried with the delay off and then with the delay on for each high-speed source. The last gated cycle and the first running cycle are sampled in each case, so an off-by-one count or a swapped length shows up. A wake pulse is also sent while the block is running, and a status write of 0 is followed by a write of 1, to show that neither the stray event nor the 0 write leaves a trace.

// File: rtl/pdwake_pkg.sv
// Package: shared types and bit positions for the power-down sequencer.
// Assumes: the control word is exactly CTRL_W bits wide, bit 0 first.
package pdwake_pkg;

    localparam int CTRL_W   = 9;
    localparam int NUM_OSC  = 4;

    localparam int B_HXT    = 0;
    localparam int B_HIRC   = 1;
    localparam int B_LXT    = 2;
    localparam int B_LIRC   = 3;
    localparam int B_DLY    = 4;
    localparam int B_IE     = 5;
    localparam int B_STS    = 6;
    localparam int B_PDREQ  = 7;
    localparam int B_WAIT   = 8;

    // Packed MSB first, so the last member lands on bit 0.
    typedef struct packed {
        logic wait_cpu;
        logic pd_req;
        logic wk_sts;
        logic wk_ie;
        logic dly_en;
        logic lirc_en;
        logic lxt_en;
        logic hirc_en;
        logic hxt_en;
    } pd_ctrl_t;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_DOWN   = 2'd1,
        ST_SETTLE = 2'd2
    } pd_state_t;

endpackage

// File: rtl/pdwake_regs.sv
// Module: control word storage.
// Does: holds the 9 control bits, applies software writes, clears the
// status bit on a write of 1, and on a wake from power-down clears the
// request bit and sets the status bit.
// Assumes: a wake update in the same cycle as a write overrides that write.
module pdwake_regs
    import pdwake_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              wake_hit_i,
    output pd_ctrl_t          ctrl_o
);

    pd_ctrl_t ctrl_q;
    pd_ctrl_t wr_val;

    // Field view of the incoming write.
    assign wr_val = pd_ctrl_t'(wr_data);

    // Register update: software write first, wake update last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (wr_en) begin
                ctrl_q.hxt_en   <= wr_val.hxt_en;
                ctrl_q.hirc_en  <= wr_val.hirc_en;
                ctrl_q.lxt_en   <= wr_val.lxt_en;
                ctrl_q.lirc_en  <= wr_val.lirc_en;
                ctrl_q.dly_en   <= wr_val.dly_en;
                ctrl_q.wk_ie    <= wr_val.wk_ie;
                ctrl_q.pd_req   <= wr_val.pd_req;
                ctrl_q.wait_cpu <= wr_val.wait_cpu;
                if (wr_val.wk_sts) begin
                    ctrl_q.wk_sts <= 1'b0;
                end
            end
            if (wake_hit_i) begin
                ctrl_q.wk_sts <= 1'b1;
                ctrl_q.pd_req <= 1'b0;
            end
        end
    end

    assign ctrl_o = ctrl_q;

    // R5: a wake leaves the status set and the request cleared.
    p_wake_updates_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wake_hit_i |=> (ctrl_q.wk_sts && !ctrl_q.pd_req));

    // R7: a write without a status 1 and without a wake never clears the status.
    p_sts_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.wk_sts && !(wr_en && wr_data[B_STS])) |=> ctrl_q.wk_sts);

endmodule

// File: rtl/pdwake_fsm.sv
// Module: entry / wake state machine with settle counter.
// Does: moves RUN -> DOWN on a request (optionally gated by CPU sleep),
// DOWN -> RUN or SETTLE on the first wake event, and SETTLE -> RUN when
// the settle count runs out.
// Assumes: wake lines are already synchronous to clk.
module pdwake_fsm
    import pdwake_pkg::*;
#(
    parameter int DLY_XTAL = 4096,
    parameter int DLY_HIRC = 256
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pd_req_i,
    input  logic      wait_cpu_i,
    input  logic      dly_en_i,
    input  logic      cpu_sleep_i,
    input  logic      wake_any_i,
    input  logic      src_hirc_i,
    output pd_state_t state_o,
    output logic      wake_hit_o
);

    localparam int DLY_MAX = (DLY_XTAL > DLY_HIRC) ? DLY_XTAL : DLY_HIRC;
    localparam int CNT_W   = $clog2(DLY_MAX);
    localparam logic [CNT_W-1:0] LOAD_XTAL = CNT_W'(DLY_XTAL - 1);
    localparam logic [CNT_W-1:0] LOAD_HIRC = CNT_W'(DLY_HIRC - 1);

    pd_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             enter;

    // Entry condition: request alone, or request plus CPU sleep.
    assign enter      = pd_req_i && (!wait_cpu_i || cpu_sleep_i);
    assign wake_hit_o = (state_q == ST_DOWN) && wake_any_i;

    // Next-state and counter load / decrement.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_RUN: begin
                if (enter) state_d = ST_DOWN;
            end
            ST_DOWN: begin
                if (wake_any_i) begin
                    if (dly_en_i) begin
                        state_d = ST_SETTLE;
                        cnt_d   = src_hirc_i ? LOAD_HIRC : LOAD_XTAL;
                    end else begin
                        state_d = ST_RUN;
                    end
                end
            end
            ST_SETTLE: begin
                if (cnt_q == '0) state_d = ST_RUN;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign state_o = state_q;

    // R2: power-down is only ever entered with the request bit set.
    p_entry_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DOWN && $past(state_q) == ST_RUN) |-> $past(pd_req_i));

    // R3: in CPU-wait mode, entry needs the CPU sleep input.
    p_entry_waits_cpu_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DOWN && $past(state_q) == ST_RUN && $past(wait_cpu_i))
            |-> $past(cpu_sleep_i));

    // R5: the first wake event ends power-down.
    p_wake_leaves_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DOWN && wake_any_i) |=> (state_q != ST_DOWN));

    // R6: the settle phase continues while count remains.
    p_settle_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE && cnt_q != '0) |=> (state_q == ST_SETTLE));

    // R9: running state is never left for settle directly.
    p_no_settle_from_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> (state_q != ST_SETTLE));

endmodule

// File: rtl/pdwake_gate.sv
// Module: output gating.
// Does: forces the masked oscillator enables, the PLL and the system clock
// off in power-down; keeps the system clock off through settling.
// Assumes: FORCE_MASK marks the sources that power-down shuts down.
module pdwake_gate
    import pdwake_pkg::*;
#(
    parameter logic [NUM_OSC-1:0] FORCE_MASK = 4'b0011
) (
    input  logic [NUM_OSC-1:0] osc_req_i,
    input  pd_state_t          state_i,
    input  logic               pll_pd_sw_i,
    output logic [NUM_OSC-1:0] osc_en_o,
    output logic               pll_pd_o,
    output logic               sysclk_en_o
);

    logic down;

    assign down = (state_i == ST_DOWN);

    // One gate per source; unmasked sources pass straight through.
    for (genvar i = 0; i < NUM_OSC; i++) begin : g_osc
        if (FORCE_MASK[i]) begin : g_forced
            assign osc_en_o[i] = osc_req_i[i] && !down;
        end else begin : g_free
            assign osc_en_o[i] = osc_req_i[i];
        end
    end

    assign pll_pd_o    = pll_pd_sw_i || down;
    assign sysclk_en_o = (state_i == ST_RUN);

endmodule

// File: rtl/pdwake_seq.sv
// Module: top of the power-down entry and wake sequencer.
// Does: ties together control storage, state machine and output gating,
// and forms the wake interrupt.
// Assumes: all inputs are synchronous to clk.
module pdwake_seq
    import pdwake_pkg::*;
#(
    parameter int NUM_WAKE = 6,
    parameter int DLY_XTAL = 4096,
    parameter int DLY_HIRC = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CTRL_W-1:0]   wr_data,
    output logic [CTRL_W-1:0]   rd_data,
    input  logic                cpu_sleep_i,
    input  logic [NUM_WAKE-1:0] wake_evt_i,
    input  logic                src_hirc_i,
    input  logic                pll_pd_sw_i,
    output logic [NUM_OSC-1:0]  osc_en_o,
    output logic                pll_pd_o,
    output logic                sysclk_en_o,
    output logic                wake_irq_o,
    output logic                pd_active_o
);

    pd_ctrl_t  ctrl;
    pd_state_t state;
    logic      wake_hit;
    logic      wake_any;

    assign wake_any = |wake_evt_i;

    pdwake_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .wake_hit_i (wake_hit),
        .ctrl_o     (ctrl)
    );

    pdwake_fsm #(
        .DLY_XTAL (DLY_XTAL),
        .DLY_HIRC (DLY_HIRC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pd_req_i    (ctrl.pd_req),
        .wait_cpu_i  (ctrl.wait_cpu),
        .dly_en_i    (ctrl.dly_en),
        .cpu_sleep_i (cpu_sleep_i),
        .wake_any_i  (wake_any),
        .src_hirc_i  (src_hirc_i),
        .state_o     (state),
        .wake_hit_o  (wake_hit)
    );

    pdwake_gate u_gate (
        .osc_req_i   ({ctrl.lirc_en, ctrl.lxt_en, ctrl.hirc_en, ctrl.hxt_en}),
        .state_i     (state),
        .pll_pd_sw_i (pll_pd_sw_i),
        .osc_en_o    (osc_en_o),
        .pll_pd_o    (pll_pd_o),
        .sysclk_en_o (sysclk_en_o)
    );

    assign rd_data     = ctrl;
    assign wake_irq_o  = ctrl.wk_sts && ctrl.wk_ie;
    assign pd_active_o = (state == ST_DOWN);

    // R4: in power-down the clock and PLL are both held off.
    p_down_gates_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pd_active_o |-> (!sysclk_en_o && pll_pd_o && !osc_en_o[B_HXT] && !osc_en_o[B_HIRC]));

    // R8: the interrupt never fires without its enable bit.
    p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq_o |-> (rd_data[B_IE] && rd_data[B_STS]));

endmodule

// File: tb/tb_pdwake_seq.sv
// Bench: scoreboard style. The driver pushes expected output snapshots into a
// queue; a monitor pops and compares them at the falling edge.
module tb_pdwake_seq;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [8:0] wr_data;
    logic [8:0] rd_data;
    logic       cpu_sleep_i;
    logic [5:0] wake_evt_i;
    logic       src_hirc_i;
    logic       pll_pd_sw_i;
    logic [3:0] osc_en_o;
    logic       pll_pd_o;
    logic       sysclk_en_o;
    logic       wake_irq_o;
    logic       pd_active_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    typedef struct {
        string       req;
        logic [16:0] exp;
    } item_t;

    item_t sb_q[$];

    always #2.5 clk = ~clk;

    pdwake_seq dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .cpu_sleep_i (cpu_sleep_i),
        .wake_evt_i  (wake_evt_i),
        .src_hirc_i  (src_hirc_i),
        .pll_pd_sw_i (pll_pd_sw_i),
        .osc_en_o    (osc_en_o),
        .pll_pd_o    (pll_pd_o),
        .sysclk_en_o (sysclk_en_o),
        .wake_irq_o  (wake_irq_o),
        .pd_active_o (pd_active_o)
    );

    // Monitor: compare every pending expectation at the falling edge.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [16:0] act;
            it  = sb_q.pop_front();
            act = {rd_data, osc_en_o, pll_pd_o, sysclk_en_o, wake_irq_o, pd_active_o};
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual rd=%h osc=%b pll=%b sys=%b irq=%b pd=%b expected rd=%h osc=%b pll=%b sys=%b irq=%b pd=%b",
                         it.req, act[16:8], act[7:4], act[3], act[2], act[1], act[0],
                         it.exp[16:8], it.exp[7:4], it.exp[3], it.exp[2], it.exp[1], it.exp[0]);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [8:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        tick();
        wr_en   = 1'b0;
    endtask

    task automatic expect_out(input string req, input logic [8:0] rd, input logic [3:0] osc,
                              input logic pll, input logic sys, input logic irq, input logic pd);
        item_t it;
        it.req = req;
        it.exp = {rd, osc, pll, sys, irq, pd};
        sb_q.push_back(it);
    endtask

    task automatic wake_pulse(input logic [5:0] v);
        wake_evt_i = v;
        tick();
        wake_evt_i = '0;
    endtask

    task automatic drain();
        @(negedge clk);
        #1;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n       = 1'b0;
        wr_en       = 1'b0;
        wr_data     = '0;
        cpu_sleep_i = 1'b0;
        wake_evt_i  = '0;
        src_hirc_i  = 1'b0;
        pll_pd_sw_i = 1'b0;
        for (int i = 0; i < 3; i++) tick();
        rst_n = 1'b1;

        // R1 reset state
        expect_out("R1 reset", 9'h000, 4'b0000, 0, 1, 0, 0);
        drain();

        // R10 readback, R2 immediate entry, R4 gating
        wr(9'h08F);
        expect_out("R10 readback", 9'h08F, 4'b1111, 0, 1, 0, 0);
        drain();
        tick();
        expect_out("R2 R4 immediate entry", 9'h08F, 4'b1100, 1, 0, 0, 1);
        drain();

        // R5 wake, R6 no delay
        wake_pulse(6'b000100);
        expect_out("R5 R6 wake without delay", 9'h04F, 4'b1111, 0, 1, 0, 0);
        drain();
        tick();
        expect_out("R5 no re-entry", 9'h04F, 4'b1111, 0, 1, 0, 0);
        drain();

        // R7 write 0 keeps status, R8 irq
        wr(9'h02F);
        expect_out("R7 R8 status kept irq on", 9'h06F, 4'b1111, 0, 1, 1, 0);
        drain();
        wr(9'h06F);
        expect_out("R7 R8 status cleared", 9'h02F, 4'b1111, 0, 1, 0, 0);
        drain();

        // R9 wake while running
        wake_pulse(6'b100000);
        expect_out("R9 stray wake", 9'h02F, 4'b1111, 0, 1, 0, 0);
        drain();

        // R3 CPU-wait entry, internal source, delay on
        src_hirc_i = 1'b1;
        wr(9'h1BF);
        for (int i = 0; i < 3; i++) tick();
        expect_out("R3 waits for CPU", 9'h1BF, 4'b1111, 0, 1, 0, 0);
        drain();
        cpu_sleep_i = 1'b1;
        tick();
        cpu_sleep_i = 1'b0;
        expect_out("R3 R4 entry on sleep", 9'h1BF, 4'b1100, 1, 0, 0, 1);
        drain();

        // R6 256-cycle settle
        wake_pulse(6'b000001);
        expect_out("R6 R8 settle start", 9'h17F, 4'b1111, 0, 0, 1, 0);
        drain();
        for (int i = 0; i < 255; i++) tick();
        expect_out("R6 last gated cycle 256", 9'h17F, 4'b1111, 0, 0, 1, 0);
        drain();
        tick();
        expect_out("R6 clock back after 256", 9'h17F, 4'b1111, 0, 1, 1, 0);
        drain();

        // R6 4096-cycle settle with crystal
        src_hirc_i = 1'b0;
        wr(9'h1BF);
        expect_out("R7 status kept on rewrite", 9'h1FF, 4'b1111, 0, 1, 1, 0);
        drain();
        cpu_sleep_i = 1'b1;
        tick();
        cpu_sleep_i = 1'b0;
        expect_out("R3 second entry", 9'h1FF, 4'b1100, 1, 0, 1, 1);
        drain();
        wake_pulse(6'b010000);
        for (int i = 0; i < 4095; i++) tick();
        expect_out("R6 last gated cycle 4096", 9'h17F, 4'b1111, 0, 0, 1, 0);
        drain();
        tick();
        expect_out("R6 clock back after 4096", 9'h17F, 4'b1111, 0, 1, 1, 0);
        drain();

        // R7 clear via write 1, R4 PLL follows software request outside power-down
        pll_pd_sw_i = 1'b1;
        wr(9'h040);
        expect_out("R7 R4 clear and PLL request", 9'h000, 4'b0000, 1, 1, 0, 0);
        drain();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule